// File: doc/BRIEF.md
# Non-Cacheable Address Region Comparator

This block decides whether a memory access must bypass the cache. It watches a 26-bit physical address and flags it as non-cacheable when the address falls inside one of two programmable regions, or inside the fixed video window C0000h–C7FFFh when that window is marked uncacheable. The cache controller samples the registered flag and skips allocation for flagged accesses.

Each region is programmed by two configuration bytes. The control byte holds an active-low enable, a two-bit size select and two high base bits. The base byte holds five weighted low base bits. The base address is the sum of the weights of the bits that are set. Bits below 512 KB are always zero. A separate video byte carries the cacheability bit for the video window. All configuration bytes are plain inputs driven by the register file that sits outside this block.

An access falls in a region when (address − base), taken modulo 2^26, is less than the region size. Both outputs are registered, so they change one clock after the address is presented.

Top module: `nc_region_cmp`

## Requirements
- R1: Control byte bits [6:5] select the region size: 00 = 64 KB, 01 = 128 KB, 10 = 256 KB, 11 = 512 KB. An all-zero configuration gives region 1 a 64 KB span at base 0.
- R2: Control byte bit 7 is an active-low enable. When it is 1, that region never flags an access.
- R3: Base byte bits 3,4,5,6,7 add 512 KB, 1 MB, 2 MB, 4 MB and 8 MB to the region base.
- R4: Control byte bit 0 adds 16 MB and bit 1 adds 32 MB to the region base.
- R5: An address is inside a region exactly when base ≤ address ≤ base + size − 1. Base − 1 and base + size are outside.
- R6: Region 2 uses bits [15:8] of both configuration inputs, with the same layout as region 1 in bits [7:0]. The two regions decode independently.
- R7: When bit 4 of the video byte is 1, addresses C0000h–C7FFFh raise `video_o`. When it is 0, or the address is outside that window, `video_o` is 0.
- R8: `nc_o` is the OR of the enabled region hits and the video hit.
- R9: Outputs are registered with one cycle of latency, and a synchronous reset clears both to 0.
- R10: Control byte bits [4:2], base byte bits [2:0] and every video byte bit other than bit 4 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 26 | Physical address of the access |
| rgn_ctl_i | input | 16 | Control bytes; region 1 in [7:0], region 2 in [15:8] |
| rgn_base_i | input | 16 | Low-base bytes; region 1 in [7:0], region 2 in [15:8] |
| vid_cfg_i | input | 8 | Video byte; bit 4 = 1 makes the video window non-cacheable |
| nc_o | output | 1 | Registered non-cacheable flag |
| video_o | output | 1 | Registered video-window hit |

## Verification
A vector table probes each region at base − 1, at base, at the last byte and at base + size. It does this for every size code, so an off-by-one bound or a swapped size code shows up as a wrong edge. The vectors also try a base built only from low weights, bases built only from high bits, and the two high bits together, which separates the weight of each bit. Other patterns toggle the enable, use region 2 alone, and set only the reserved bits, which shows that the regions are independent and that ignored bits really are ignored. Directed steps probe the video window edges with the bit both set and clear, check the one-cycle latency, and apply reset while an address is hitting.

// File: rtl/nc_pkg.sv
package nc_pkg;
  // bit positions of the weighted base and size fields
  localparam int unsigned LOW_SHIFT  = 19;  // 512 KB granule
  localparam int unsigned HIGH_SHIFT = 24;  // 16 MB granule
  localparam int unsigned SIZE_SHIFT = 16;  // smallest span 64 KB

  typedef struct packed {
    logic       dis_n;     // 1 = region off
    logic [1:0] size_sel;
    logic [2:0] rsvd;
    logic [1:0] hi;
  } nc_ctl_t;

  typedef struct packed {
    logic [4:0] lo;
    logic [2:0] rsvd;
  } nc_base_t;
endpackage

// File: rtl/nc_cfg_decode.sv
module nc_cfg_decode
  import nc_pkg::*;
#(
  parameter int unsigned ADDR_W = 26
) (
  input  logic [7:0]        ctl_byte,
  input  logic [7:0]        base_byte,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] size,
  output logic              en
);
  nc_ctl_t  ctl;
  nc_base_t bb;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    ctl  = nc_ctl_t'(ctl_byte);
    bb   = nc_base_t'(base_byte);
    en   = ~ctl.dis_n;
    base = (ADDR_W'(bb.lo) << LOW_SHIFT) | (ADDR_W'(ctl.hi) << HIGH_SHIFT);
    size = ONE << (SIZE_SHIFT + 32'(ctl.size_sel));
  end
endmodule

// File: rtl/nc_range_match.sv
module nc_range_match #(
  parameter int unsigned ADDR_W = 26
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic              en,
  output logic              hit
);
  logic [ADDR_W-1:0] offs;

  always_comb begin
    // modular difference: below-base addresses wrap to a large value
    offs = addr - base;
    hit  = en && (offs < size);
  end
endmodule

// File: rtl/nc_video_match.sv
module nc_video_match #(
  parameter int unsigned ADDR_W  = 26,
  parameter logic [31:0] WIN_LO  = 32'h000C_0000,
  parameter logic [31:0] WIN_HI  = 32'h000C_7FFF,
  parameter int unsigned CTL_BIT = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        vid_cfg,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_HI);

  always_comb hit = vid_cfg[CTL_BIT] && (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/nc_region_cmp.sv
module nc_region_cmp #(
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned NUM_RGN = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_RGN*8-1:0] rgn_ctl_i,
  input  logic [NUM_RGN*8-1:0] rgn_base_i,
  input  logic [7:0]           vid_cfg_i,
  output logic                 nc_o,
  output logic                 video_o
);
  logic [NUM_RGN-1:0] rgn_hit;
  logic               vid_hit;

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic              en;

    nc_cfg_decode #(.ADDR_W(ADDR_W)) dec_i (
      .ctl_byte  (rgn_ctl_i[r*8 +: 8]),
      .base_byte (rgn_base_i[r*8 +: 8]),
      .base      (base),
      .size      (size),
      .en        (en)
    );

    nc_range_match #(.ADDR_W(ADDR_W)) cmp_i (
      .addr (addr_i),
      .base (base),
      .size (size),
      .en   (en),
      .hit  (rgn_hit[r])
    );
  end

  nc_video_match #(.ADDR_W(ADDR_W)) vid_i (
    .addr    (addr_i),
    .vid_cfg (vid_cfg_i),
    .hit     (vid_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nc_o    <= 1'b0;
      video_o <= 1'b0;
    end else begin
      nc_o    <= (|rgn_hit) | vid_hit;
      video_o <= vid_hit;
    end
  end
endmodule

// File: rtl/nc_region_cmp_chk.sv
module nc_region_cmp_chk #(
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned NUM_RGN = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [NUM_RGN*8-1:0] rgn_ctl_i,
  input logic [7:0]           vid_cfg_i,
  input logic                 nc_o,
  input logic                 video_o
);
  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int r = 0; r < NUM_RGN; r++) all_off &= rgn_ctl_i[r*8+7];
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!nc_o && !video_o));

  // R8
  video_implies_nc_chk: assert property (@(posedge clk) disable iff (rst)
    video_o |-> nc_o);

  // R7
  video_window_chk: assert property (@(posedge clk) disable iff (rst)
    video_o |-> ($past(addr_i) >= ADDR_W'(32'hC0000) && $past(addr_i) <= ADDR_W'(32'hC7FFF)));

  // R7
  video_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(vid_cfg_i[4]) |-> !video_o);

  // R2
  disabled_regions_chk: assert property (@(posedge clk) disable iff (rst)
    (nc_o && !video_o) |-> !$past(all_off));
endmodule

bind nc_region_cmp nc_region_cmp_chk #(.ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .addr_i    (addr_i),
  .rgn_ctl_i (rgn_ctl_i),
  .vid_cfg_i (vid_cfg_i),
  .nc_o      (nc_o),
  .video_o   (video_o)
);

// File: tb/nc_region_cmp_tb_top.sv
module nc_region_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] addr = '0;
  logic [15:0] ctl = '0;
  logic [15:0] base = '0;
  logic [7:0]  vid = '0;
  logic        nc_o, video_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  nc_region_cmp dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .rgn_ctl_i(ctl),
    .rgn_base_i(base), .vid_cfg_i(vid), .nc_o(nc_o), .video_o(video_o)
  );

  // {ctl, base, vid, addr, exp_nc, exp_vid, req tag}
  typedef struct packed {
    logic [15:0] c; logic [15:0] b; logic [7:0] v; logic [25:0] a;
    logic en; logic ev; logic [31:0] tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{16'h0000, 16'h0000, 8'h00, 26'h000FFFF, 1'b1, 1'b0, "R1"},
    '{16'h0000, 16'h0000, 8'h00, 26'h0010000, 1'b0, 1'b0, "R5"},
    '{16'h9C9C, 16'h0000, 8'h00, 26'h0000000, 1'b0, 1'b0, "R2"},
    '{16'h9C3C, 16'h0008, 8'h00, 26'h009FFFF, 1'b1, 1'b0, "R1"},
    '{16'h9C3C, 16'h0008, 8'h00, 26'h00A0000, 1'b0, 1'b0, "R5"},
    '{16'h9C3C, 16'h0008, 8'h00, 26'h007FFFF, 1'b0, 1'b0, "R5"},
    '{16'h9C3C, 16'h0008, 8'h00, 26'h0080000, 1'b1, 1'b0, "R5"},
    '{16'h9C5C, 16'h0010, 8'h00, 26'h013FFFF, 1'b1, 1'b0, "R1"},
    '{16'h9C5C, 16'h0010, 8'h00, 26'h0140000, 1'b0, 1'b0, "R1"},
    '{16'h9C7C, 16'h00F8, 8'h00, 26'h0FFFFFF, 1'b1, 1'b0, "R3"},
    '{16'h9C7C, 16'h00F8, 8'h00, 26'h1000000, 1'b0, 1'b0, "R3"},
    '{16'h9C7C, 16'h00F8, 8'h00, 26'h0F7FFFF, 1'b0, 1'b0, "R3"},
    '{16'h9C1D, 16'h0000, 8'h00, 26'h100FFFF, 1'b1, 1'b0, "R4"},
    '{16'h9C1D, 16'h0000, 8'h00, 26'h0000000, 1'b0, 1'b0, "R4"},
    '{16'h9C1E, 16'h0000, 8'h00, 26'h2000000, 1'b1, 1'b0, "R4"},
    '{16'h9C1F, 16'h0000, 8'h00, 26'h3000010, 1'b1, 1'b0, "R4"},
    '{16'h3C9C, 16'h1000, 8'h00, 26'h011FFFF, 1'b1, 1'b0, "R6"},
    '{16'h3C9C, 16'h1000, 8'h00, 26'h0120000, 1'b0, 1'b0, "R6"},
    '{16'hBC1C, 16'h1000, 8'h00, 26'h0100000, 1'b0, 1'b0, "R6"},
    '{16'h9C80, 16'h0707, 8'h00, 26'h0000000, 1'b0, 1'b0, "R10"},
    '{16'h9C00, 16'h0007, 8'h00, 26'h000FFFF, 1'b1, 1'b0, "R10"},
    '{16'h9C9C, 16'h0000, 8'hEF, 26'h00C0000, 1'b0, 1'b0, "R10"},
    '{16'h0000, 16'h0000, 8'h10, 26'h00C0000, 1'b1, 1'b1, "R8"},
    '{16'h0000, 16'h0000, 8'h10, 26'h0000000, 1'b1, 1'b0, "R8"}
  };

  task automatic check(input logic exp_nc, input logic exp_v, input string req);
    n_chk++;
    if (nc_o !== exp_nc || video_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s: nc_o=%b video_o=%b expected nc_o=%b video_o=%b (addr=%h)",
               req, nc_o, video_o, exp_nc, exp_v, addr);
    end
  endtask

  // drive at negedge, output registered at next posedge, sample at following negedge
  task automatic apply(input logic [15:0] c, input logic [15:0] b, input logic [7:0] v,
                       input logic [25:0] a, input logic exp_nc, input logic exp_v,
                       input string req);
    ctl = c; base = b; vid = v; addr = a;
    @(negedge clk);
    check(exp_nc, exp_v, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R9");          // reset state
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      apply(VT[i].c, VT[i].b, VT[i].v, VT[i].a, VT[i].en, VT[i].ev, string'(VT[i].tag));

    // R7 video window edges
    apply(16'h9C9C, 16'h0000, 8'h10, 26'h00C0000, 1'b1, 1'b1, "R7");
    apply(16'h9C9C, 16'h0000, 8'h10, 26'h00C7FFF, 1'b1, 1'b1, "R7");
    apply(16'h9C9C, 16'h0000, 8'h10, 26'h00C8000, 1'b0, 1'b0, "R7");
    apply(16'h9C9C, 16'h0000, 8'h10, 26'h00BFFFF, 1'b0, 1'b0, "R7");
    apply(16'h9C9C, 16'h0000, 8'h00, 26'h00C4000, 1'b0, 1'b0, "R7");

    // R9 latency: output still old value just after the change, new after the edge
    ctl = 16'h9C9C; vid = 8'h00; addr = 26'h0;
    @(negedge clk);
    ctl = 16'h0000; addr = 26'h0000100;
    #1 check(1'b0, 1'b0, "R9");
    @(posedge clk); #1 check(1'b1, 1'b0, "R9");

    // R9 reset while an access is hitting
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, "R9");
    rst = 1'b0;
    @(negedge clk);
    check(1'b1, 1'b0, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule